// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM whose bus can carry a read on one clock and a write on the next, in any mix, with no idle cycles between them. Every input is registered on the rising clock edge. A read returns its word two enabled edges after its address was taken. A write takes its data two enabled edges after its address, so read data and write data use the same bus slots. This gives full bus utilisation.

Each new access is started by a load cycle. The address and operation of that load are kept, and the cycles after it can advance a 2-bit burst counter through a four-word group. The group is walked in linear or interleaved order, chosen at load time. A read that lands on a word whose write is still in flight gets the in-flight data, merged byte by byte with the stored word. An active-low clock enable freezes the whole pipeline, including the outputs.

Top module: `zt_sram`

## Requirements
- R1: A read whose address is registered at enabled edge k drives its word on `rdata_o`, with `oe_o` high, after enabled edge k+2. `oe_o` is low after any edge whose op two enabled edges back was not a read.
- R2: While `clk_en_ni` is high, every other synchronous input is ignored. The memory, burst state, pipeline, `rdata_o` and `oe_o` all keep their values.
- R3: A load cycle (`adv_ld_i` low) is a read when `we_ni` is high and a write when `we_ni` is low, but only if `ce0_ni`=0, `ce1_i`=1 and `ce2_ni`=0. Any other chip-enable state makes it a deselect that neither reads nor writes.
- R4: Write data is taken from `wdata_i` at the second enabled edge after the write address. Lane l is bits [9l+8:9l]. The lane is written only if `bw_ni[l]` was low together with that address.
- R5: Reads and writes may alternate on every enabled cycle with no idle cycle, and each one still completes correctly.
- R6: A read issued one enabled cycle after a write to the same address returns that write's data in the lanes it enables, and the earlier contents in the other lanes.
- R7: An advance cycle (`adv_ld_i` high) repeats the operation of the most recent load at the next burst address, using the byte enables of the advance cycle. If that load was a deselect, the advance is a deselect too.
- R8: With `burst_ilv_i` low at the load, the n-th advance uses address bits [1:0] = (base + n) mod 4. The upper address bits are unchanged, and the burst wraps inside its aligned four-word group.
- R9: With `burst_ilv_i` high at the load, the n-th advance uses address bits [1:0] = base[1:0] XOR (n mod 4). The burst order is latched at the load, and the level of `burst_ilv_i` on advance cycles has no effect.
- R10: Asynchronous reset empties the pipeline and drives `oe_o` low and `rdata_o` to zero. A write whose address was accepted before the reset is never performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld_i | input | 1 | 0 = load new access, 1 = advance burst |
| addr_i | input | ADDR_W (8) | Word address for load cycles |
| we_ni | input | 1 | 0 = write, 1 = read (load cycles) |
| bw_ni | input | LANES (2) | Per-lane write enables, active low |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| burst_ilv_i | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| wdata_i | input | LANES*LANE_W (18) | Write data, two cycles behind its address |
| rdata_o | output | LANES*LANE_W (18) | Read data |
| oe_o | output | 1 | High while `rdata_o` carries a read result |

## Verification
The bench builds the block with its defaults: 8 address bits and two 9-bit lanes. At that size the whole array can be preloaded through bursts in a few hundred cycles, and every word can then be predicted. The random traffic is confined to 16 addresses. This makes write-then-read hits on the same word frequent, so byte-merged forwarding is exercised, along with burst wraps inside a group and stalls that land between a write address and its data.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  localparam int BURST_W = 2;
endpackage

// File: rtl/zt_sram_lane.sv
`timescale 1ns/1ps
module zt_sram_lane #(
  parameter int ADDR_W = 8,
  parameter int W      = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/zt_sram_burst.sv
`timescale 1ns/1ps
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              ilv_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt, low;
  logic              ilv_q;

  assign cnt_nxt = cnt_q + BURST_W'(1);
  assign low     = ilv_q ? (base_q[BURST_W-1:0] ^ cnt_nxt)
                         : (base_q[BURST_W-1:0] + cnt_nxt);
  assign be_o    = be_i;

  always_comb begin
    if (load_i) begin
      op_o   = sel_i ? (wr_i ? OP_WR : OP_RD) : OP_IDLE;
      addr_o = addr_i;
    end else begin
      op_o   = op_q;
      addr_o = {base_q[ADDR_W-1:BURST_W], low};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        op_q   <= sel_i ? (wr_i ? OP_WR : OP_RD) : OP_IDLE;
        base_q <= addr_i;
        cnt_q  <= '0;
        ilv_q  <= ilv_i;
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assert_lin_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && !ilv_i) ##1 (en_i && !load_i)
      |-> (addr_o[1:0] == $past(addr_i[1:0]) + 2'd1)
          && (addr_o[ADDR_W-1:2] == $past(addr_i[ADDR_W-1:2])));

  assert_ilv_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && ilv_i) ##1 (en_i && !load_i)
      |-> addr_o[1:0] == ($past(addr_i[1:0]) ^ 2'd1));

  assert_desel_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && !sel_i) ##1 (en_i && !load_i) |-> op_o == OP_IDLE);
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              adv_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic              burst_ilv_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  logic en, sel;
  assign en  = !clk_en_ni;
  assign sel = !ce0_ni && ce1_i && !ce2_ni;

  op_e               s0_op, c1_op, c2_op;
  logic [ADDR_W-1:0] s0_addr, c1_addr, c2_addr;
  logic [LANES-1:0]  s0_be, c1_be, c2_be;
  logic [DATA_W-1:0] rd_mux, rd_q;
  logic              rd_v_q;

  zt_sram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (!adv_ld_i),
    .sel_i  (sel),
    .wr_i   (!we_ni),
    .addr_i (addr_i),
    .be_i   (~bw_ni),
    .ilv_i  (burst_ilv_i),
    .op_o   (s0_op),
    .addr_o (s0_addr),
    .be_o   (s0_be)
  );

  // Array reads for stage 1, writes retire from stage 2 with live wdata_i.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] arr_rd;
    logic              lane_we, fwd;
    assign lane_we = en && (c2_op == OP_WR) && c2_be[l];
    assign fwd     = (c2_op == OP_WR) && c2_be[l] && (c2_addr == c1_addr);

    zt_sram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .we_i    (lane_we),
      .waddr_i (c2_addr),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .raddr_i (c1_addr),
      .rdata_o (arr_rd)
    );

    assign rd_mux[l*LANE_W +: LANE_W] = fwd ? wdata_i[l*LANE_W +: LANE_W] : arr_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_op   <= OP_IDLE;
      c2_op   <= OP_IDLE;
      c1_addr <= '0;
      c2_addr <= '0;
      c1_be   <= '0;
      c2_be   <= '0;
      rd_q    <= '0;
      rd_v_q  <= 1'b0;
      rdata_o <= '0;
      oe_o    <= 1'b0;
    end else if (en) begin
      c1_op   <= s0_op;
      c1_addr <= s0_addr;
      c1_be   <= s0_be;
      c2_op   <= c1_op;
      c2_addr <= c1_addr;
      c2_be   <= c1_be;
      rd_v_q  <= (c1_op == OP_RD);
      if (c1_op == OP_RD) rd_q <= rd_mux;
      oe_o    <= rd_v_q;
      if (rd_v_q) rdata_o <= rd_q;
    end
  end

  assert_stall_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(rdata_o) && $stable(oe_o));

  assert_rd_oe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && rd_v_q) |=> oe_o);

  assert_no_oe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !rd_v_q) |=> !oe_o);
endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW   = 8;
  localparam int LW   = 9;
  localparam int LN   = 2;
  localparam int DW   = LW * LN;
  localparam int ADEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clk_en_ni = 1'b0;
  logic          adv_ld_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_ni = 1'b1;
  logic [LN-1:0] bw_ni = '1;
  logic          ce0_ni = 1'b1;
  logic          ce1_i = 1'b0;
  logic          ce2_ni = 1'b1;
  logic          burst_ilv_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          oe_o;

  always #2.5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(LN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .adv_ld_i(adv_ld_i),
    .addr_i(addr_i), .we_ni(we_ni), .bw_ni(bw_ni), .ce0_ni(ce0_ni),
    .ce1_i(ce1_i), .ce2_ni(ce2_ni), .burst_ilv_i(burst_ilv_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .oe_o(oe_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference state: 0 idle, 1 read, 2 write
  logic [DW-1:0] mem_m [ADEP];
  int            m_op, m_cnt;
  logic [AW-1:0] m_base;
  bit            m_ilv;
  int            p1_op, p2_op;
  logic [AW-1:0] p1_addr, p2_addr;
  logic [LN-1:0] p1_be, p2_be;
  bit            exp_oe;
  logic [DW-1:0] exp_data;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_op = 0; m_cnt = 0; m_base = '0; m_ilv = 1'b0;
    p1_op = 0; p2_op = 0; p1_addr = '0; p2_addr = '0; p1_be = '0; p2_be = '0;
    exp_oe = 1'b0; exp_data = '0;
  endfunction

  // desel: 0 selected, 1..3 drop one chip enable
  task automatic step(input bit en, input bit ld, input int a, input bit wr,
                      input logic [LN-1:0] be, input int desel, input bit il,
                      input string tag);
    logic [DW-1:0] wd;
    int            nop;
    logic [AW-1:0] naddr;
    logic [1:0]    low;
    @(negedge clk);
    wd          = DW'($urandom);
    clk_en_ni   = !en;
    adv_ld_i    = !ld;
    addr_i      = a[AW-1:0];
    we_ni       = !wr;
    bw_ni       = ~be;
    ce0_ni      = (desel == 1);
    ce1_i       = (desel != 2);
    ce2_ni      = (desel == 3);
    burst_ilv_i = il;
    wdata_i     = wd;
    @(posedge clk);
    #1;
    if (en) begin
      if (p2_op == 2)
        for (int l = 0; l < LN; l++)
          if (p2_be[l]) mem_m[p2_addr][l*LW +: LW] = wd[l*LW +: LW];
      if (p2_op == 1) begin
        exp_oe = 1'b1;
        exp_data = mem_m[p2_addr];
      end else begin
        exp_oe = 1'b0;
      end
      if (ld) begin
        nop    = (desel == 0) ? (wr ? 2 : 1) : 0;
        naddr  = a[AW-1:0];
        m_op   = nop; m_base = a[AW-1:0]; m_cnt = 0; m_ilv = il;
      end else begin
        nop = m_op;
        if (m_op != 0) m_cnt = (m_cnt + 1) % 4;
        low   = m_ilv ? (m_base[1:0] ^ 2'((m_cnt + (m_op == 0 ? 1 : 0)) % 4))
                      : 2'((int'(m_base[1:0]) + m_cnt + (m_op == 0 ? 1 : 0)) % 4);
        naddr = {m_base[AW-1:2], low};
      end
      p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be;
      p1_op = nop;   p1_addr = naddr;   p1_be = be;
    end
    chk(oe_o === exp_oe, tag, DW'(oe_o), DW'(exp_oe));
    if (exp_oe) chk(rdata_o === exp_data, tag, rdata_o, exp_data);
  endtask

  task automatic ld_rd(input int a, input bit il, input string tag);
    step(1'b1, 1'b1, a, 1'b0, LN'($urandom), 0, il, tag);
  endtask
  task automatic ld_wr(input int a, input logic [LN-1:0] be, input bit il, input string tag);
    step(1'b1, 1'b1, a, 1'b1, be, 0, il, tag);
  endtask
  task automatic adv(input logic [LN-1:0] be, input string tag);
    step(1'b1, 1'b0, int'($urandom % ADEP), 1'($urandom), be, 0, 1'($urandom), tag);
  endtask
  task automatic nop(input string tag);
    step(1'b1, 1'b1, int'($urandom % ADEP), 1'($urandom), LN'($urandom),
         1 + int'($urandom % 3), 1'($urandom), tag);
  endtask
  task automatic stall(input string tag);
    step(1'b0, 1'($urandom), int'($urandom % ADEP), 1'($urandom), LN'($urandom),
         0, 1'($urandom), tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    ce0_ni = 1'b1; ce1_i = 1'b0; ce2_ni = 1'b1; clk_en_ni = 1'b0; adv_ld_i = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    chk(oe_o === 1'b0, tag, DW'(oe_o), '0);
    chk(rdata_o === '0, tag, rdata_o, '0);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_clear();
    // R10: reset state
    do_reset("R10");

    // Preload every word with linear write bursts (R7, R8)
    for (int g = 0; g < ADEP / 4; g++) begin
      ld_wr(g * 4, '1, 1'b0, "R7");
      repeat (3) adv('1, "R7");
    end
    repeat (2) nop("R7");

    // R1: plain read latency
    ld_rd(5, 1'b0, "R1");
    nop("R1"); nop("R1"); nop("R1");

    // R3: each inactive chip enable blocks a write; deselected read gives no oe
    for (int d = 1; d <= 3; d++) step(1'b1, 1'b1, 9, 1'b1, '1, d, 1'b0, "R3");
    step(1'b1, 1'b1, 9, 1'b0, '0, 2, 1'b0, "R3");
    nop("R3"); nop("R3");
    ld_rd(9, 1'b0, "R3");
    nop("R3"); nop("R3");

    // R4: single-lane writes
    ld_wr(12, 2'b01, 1'b0, "R4");
    ld_wr(13, 2'b10, 1'b0, "R4");
    ld_wr(14, 2'b00, 1'b0, "R4");
    nop("R4"); nop("R4");
    ld_rd(12, 1'b0, "R4"); ld_rd(13, 1'b0, "R4"); ld_rd(14, 1'b0, "R4");
    nop("R4"); nop("R4");

    // R5: strict alternation
    for (int i = 0; i < 24; i++) begin
      if (i % 2 == 0) ld_wr(int'($urandom % 8), LN'($urandom), 1'b0, "R5");
      else            ld_rd(int'($urandom % 8), 1'b0, "R5");
    end
    nop("R5"); nop("R5");

    // R6: read right behind a write to the same word
    ld_wr(20, 2'b10, 1'b0, "R6"); ld_rd(20, 1'b0, "R6");
    ld_wr(21, 2'b11, 1'b0, "R6"); ld_rd(21, 1'b0, "R6");
    ld_wr(22, 2'b01, 1'b0, "R6"); ld_rd(22, 1'b0, "R6");
    nop("R6"); nop("R6");

    // R8: linear read burst from an unaligned base, including wrap
    ld_rd(8'h42, 1'b0, "R8");
    repeat (4) adv('0, "R8");
    ld_wr(8'h53, 2'b11, 1'b0, "R8");
    repeat (3) adv(2'b11, "R8");
    ld_rd(8'h50, 1'b0, "R8");
    repeat (3) adv('0, "R8");
    nop("R8"); nop("R8");

    // R9: interleaved bursts; advance-cycle order input toggled freely
    ld_rd(8'h4b, 1'b1, "R9");
    repeat (3) adv('0, "R9");
    ld_wr(8'h6e, 2'b11, 1'b1, "R9");
    repeat (3) adv(2'b11, "R9");
    ld_rd(8'h6c, 1'b0, "R9");
    repeat (3) adv('0, "R9");
    nop("R9"); nop("R9");

    // R7: advance after a deselect load must not write
    step(1'b1, 1'b1, 8'h70, 1'b1, '1, 3, 1'b0, "R7");
    repeat (3) adv(2'b11, "R7");
    ld_rd(8'h70, 1'b0, "R7");
    repeat (3) adv('0, "R7");
    ld_wr(8'h75, 2'b10, 1'b0, "R7");
    adv(2'b01, "R7");
    ld_rd(8'h74, 1'b0, "R7");
    repeat (3) adv('0, "R7");
    nop("R7"); nop("R7");

    // R2: stalls at every pipeline position
    ld_rd(3, 1'b0, "R2");
    repeat (3) stall("R2");
    nop("R2");
    stall("R2");
    nop("R2");
    ld_wr(30, 2'b11, 1'b0, "R2");
    stall("R2");
    nop("R2");
    repeat (2) stall("R2");
    nop("R2");
    ld_rd(30, 1'b0, "R2");
    stall("R2");
    nop("R2"); stall("R2"); nop("R2");

    // R5: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      bit en_r = ($urandom % 100) >= 8;
      bit ld_r = ($urandom % 3) != 0;
      int ds   = (($urandom % 8) == 0) ? 1 + int'($urandom % 3) : 0;
      step(en_r, ld_r, int'($urandom % 16), 1'($urandom), LN'($urandom), ds,
           1'($urandom), "R5");
    end
    nop("R5"); nop("R5");

    // R10: reset drops a write already accepted
    ld_wr(40, 2'b11, 1'b0, "R10");
    do_reset("R10");
    ld_rd(40, 1'b0, "R10");
    nop("R10"); nop("R10"); nop("R10");

    finish_run();
  end
endmodule